// File: doc/BRIEF.md
# Serial Memory Write Front End (I2C Slave)

This block is the write side of an I2C slave that sits in front of a 512-byte nonvolatile array. It oversamples the SCL and SDA lines on the system clock, finds START and STOP conditions, and decodes the device-select byte. When a host opens a write, the block takes a word address and then passes each data byte to a page buffer as a one-cycle write strobe carrying a 9-bit address. Inside a 16-byte page the address counts up and wraps. A one-cycle commit pulse, raised on the closing STOP, tells the array controller to start its internal program cycle.

While the array reports busy, the block ignores the bus completely. A host can therefore poll with a write-direction select byte until it is acknowledged. A write-protect input guards the upper 256 bytes. That input is captured once per transaction, and a protected data byte is refused. The SDA pin is driven only through an active-high pull-low enable, and the pad itself is outside this block.

Top module: `i2c_mem_wr_slave`

## Requirements
- R1: After reset sda_oe, pb_we and commit_o are all 0.
- R2: The select byte is sent MSB first as 1010, A2, A1, P, RW. It is acknowledged only when bits 7..4 are 1010, bits 3..2 equal dev_sel[1:0], RW (bit 0) is 0 and busy_i is low. P (bit 1) becomes address bit 8.
- R3: After the word-address byte is acknowledged, the first data byte is acknowledged and appears on pb_we with pb_addr = {P, word address} and pb_data = the byte.
- R4: Each further data byte goes to the next address. Only pb_addr[3:0] advances, wrapping from 15 to 0, and pb_addr[8:4] stays fixed.
- R5: commit_o is a single-cycle pulse on a STOP that closes a write in which at least one data byte was accepted. A write with no data byte gives no pulse. commit_o and pb_we are never high in the same cycle.
- R6: While busy_i is high, no select byte is acknowledged, there is no pb_we, and the STOP gives no commit. Once busy_i is low, the same select byte is acknowledged.
- R7: wp_i is captured on the SCL falling edge that ends the word-address acknowledge. If it was captured high and P = 1, the data byte is not acknowledged, nothing is written and no commit follows.
- R8: When P = 0, wp_i has no effect. A change of wp_i after the capture point does not change the outcome of that transaction.
- R9: A START or STOP after two or more bits of a byte aborts the transfer: no commit follows, even for bytes already accepted. A START re-enters select decoding.
- R10: sda_oe goes high only in an acknowledge clock and changes only while SCL is low.
- R11: A select byte with RW = 1 is not acknowledged and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| dev_sel | input | 2 | Strapped A2, A1 select bits |
| wp_i | input | 1 | Write protect for the upper half |
| busy_i | input | 1 | Internal program cycle in progress |
| pb_we | output | 1 | Page-buffer byte write strobe |
| pb_addr | output | 9 | Address for pb_we |
| pb_data | output | 8 | Byte for pb_we |
| commit_o | output | 1 | Start of the program cycle |

## Verification
Two things can land on the same transaction boundary: the commit decided on STOP, and the abort of an unfinished byte. The bench sends STOPs both exactly after an acknowledge and after a few bits of a following byte. It expects a commit pulse only in the first case, even though bytes were already strobed into the buffer in both. Along the same lines, wp_i is toggled just after its capture edge in both directions, and the outcome must follow the captured level and not the later one.

// File: rtl/eew_pkg.sv
package eew_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_HOLD
  } eew_st_t;
endpackage

// File: rtl/eew_sync_bit.sv
module eew_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eew_bus_cond.sv
module eew_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic scl_d, sda_d;

  eew_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
  eew_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eew_proto_fsm.sv
module eew_proto_fsm
  import eew_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [1:0]        dev_sel,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              sda_oe,
  output logic              pb_we,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [BYTE_W-1:0] pb_data,
  output logic              commit_o,
  output logic              wp_lat,
  output logic              in_ack
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  eew_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [ADDR_W-1:0] addr;
  logic              wrote;
  logic              sel_ok;
  logic              byte_st;

  assign sel_ok  = (shreg[7:4] == DEV_TYPE) && (shreg[3:2] == dev_sel) &&
                   !shreg[0] && !busy_i;
  assign byte_st = (st == ST_DEV) || (st == ST_WADR) || (st == ST_DATA);
  assign in_ack  = (st == ST_DEV_ACK) || (st == ST_WADR_ACK) || (st == ST_DATA_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      addr     <= '0;
      wrote    <= 1'b0;
      wp_lat   <= 1'b0;
      sda_oe   <= 1'b0;
      pb_we    <= 1'b0;
      pb_addr  <= '0;
      pb_data  <= '0;
      commit_o <= 1'b0;
    end else begin
      pb_we    <= 1'b0;
      commit_o <= 1'b0;
      if (start_p) begin
        st     <= ST_DEV;
        cnt    <= '0;
        wrote  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        if (wrote && st == ST_DATA && cnt <= ONE) commit_o <= 1'b1;
        st     <= ST_IDLE;
        wrote  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (byte_st) begin
          shreg <= {shreg[BYTE_W-2:0], sda_s};
          cnt   <= cnt + ONE;
        end
      end else if (scl_fall) begin
        case (st)
          ST_DEV: if (cnt == FULL) begin
            if (sel_ok) begin
              sda_oe           <= 1'b1;
              addr[ADDR_W-1]   <= shreg[1];
              st               <= ST_DEV_ACK;
            end else begin
              st <= ST_HOLD;
            end
          end
          ST_DEV_ACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_WADR;
          end
          ST_WADR: if (cnt == FULL) begin
            addr[ADDR_W-2:0] <= shreg[ADDR_W-2:0];
            sda_oe           <= 1'b1;
            st               <= ST_WADR_ACK;
          end
          ST_WADR_ACK: begin
            sda_oe <= 1'b0;
            wp_lat <= wp_i;
            cnt    <= '0;
            st     <= ST_DATA;
          end
          ST_DATA: if (cnt == FULL) begin
            if (wp_lat && addr[ADDR_W-1]) begin
              wrote <= 1'b0;
              st    <= ST_HOLD;
            end else begin
              pb_we               <= 1'b1;
              pb_addr             <= addr;
              pb_data             <= shreg;
              addr[PAGE_W-1:0]    <= addr[PAGE_W-1:0] + PAGE_W'(1);
              wrote               <= 1'b1;
              sda_oe              <= 1'b1;
              st                  <= ST_DATA_ACK;
            end
          end
          ST_DATA_ACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_wr_slave.sv
module i2c_mem_wr_slave
  import eew_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        dev_sel,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              pb_we,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [BYTE_W-1:0] pb_data,
  output logic              commit_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic wp_lat, in_ack;

  eew_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p));

  eew_proto_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .dev_sel(dev_sel), .wp_i(wp_i), .busy_i(busy_i), .sda_oe(sda_oe),
    .pb_we(pb_we), .pb_addr(pb_addr), .pb_data(pb_data),
    .commit_o(commit_o), .wp_lat(wp_lat), .in_ack(in_ack));
endmodule

// File: rtl/eew_chk.sv
module eew_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              pb_we,
  input logic [ADDR_W-1:0] pb_addr,
  input logic              commit_o,
  input logic              scl_s,
  input logic              wp_lat,
  input logic              in_ack
);
  // R5
  commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  // R5
  commit_vs_we_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit_o && pb_we));

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R10
  oe_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> in_ack);

  // R7
  wp_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (pb_we && pb_addr[ADDR_W-1]) |-> !wp_lat);
endmodule

bind i2c_mem_wr_slave eew_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .pb_we(pb_we), .pb_addr(pb_addr),
  .commit_o(commit_o), .scl_s(scl_s), .wp_lat(wp_lat), .in_ack(in_ack));

// File: tb/i2c_mem_wr_slave_tb.sv
module i2c_mem_wr_slave_tb;
  localparam int Q = 6;
  localparam int H = 10;
  localparam logic [1:0] SEL = 2'b01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_oe, pb_we, commit_o;
  logic [8:0] pb_addr;
  logic [7:0] pb_data;
  logic sda_line;

  int total = 0, bad = 0;
  int wr_cnt = 0, com_cnt = 0, oe_viol = 0;
  logic [8:0] log_addr [64];
  logic [7:0] log_data [64];
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_mem_wr_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(SEL), .wp_i(wp), .busy_i(busy), .pb_we(pb_we),
    .pb_addr(pb_addr), .pb_data(pb_data), .commit_o(commit_o));

  always @(negedge clk) begin
    if (!rst) begin
      if (pb_we) begin
        if (wr_cnt < 64) begin
          log_addr[wr_cnt] = pb_addr;
          log_data[wr_cnt] = pb_data;
        end
        wr_cnt++;
      end
      if (commit_o) com_cnt++;
      // R10: the enable must never move while SCL is high
      if (sda_oe != prev_oe && m_scl) oe_viol++;
    end
    prev_oe = sda_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wclk(Q); m_scl = 1'b1; wclk(Q);
    m_sda = 1'b0; wclk(Q); m_scl = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wclk(Q); m_scl = 1'b1; wclk(Q);
    m_sda = 1'b1; wclk(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wclk(Q); m_scl = 1'b1; wclk(H); m_scl = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; wclk(Q); m_scl = 1'b1; wclk(H / 2);
    ack = ~sda_line;
    wclk(H / 2); m_scl = 1'b0; wclk(Q);
  endtask

  function automatic logic [7:0] sel_byte(input logic p, input logic rw);
    return {4'b1010, SEL, p, rw};
  endfunction

  initial begin
    bit ack;
    int w0, c0;
    logic [8:0] a;
    wclk(5);
    rst = 1'b0;
    wclk(2);
    // R1
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(pb_we == 1'b0, "R1 pb_we", pb_we, 0);
    chk(commit_o == 1'b0, "R1 commit_o", commit_o, 0);

    // R2: sweep every 7-bit select value in write direction
    c0 = com_cnt;
    for (int v = 0; v < 128; v++) begin
      bit e;
      i2c_start();
      send_byte({v[6:0], 1'b0}, ack);
      i2c_stop();
      e = (v[6:3] == 4'b1010) && (v[2:1] == SEL);
      chk(ack == e, $sformatf("R2 select %0h", v), ack, e);
    end
    // R5: address-only transactions never commit
    chk(com_cnt == c0, "R5 no commit w/o data", com_cnt, c0);

    // R11
    i2c_start(); send_byte(sel_byte(1'b0, 1'b1), ack); i2c_stop();
    chk(ack == 1'b0, "R11 read dir", ack, 0);

    // R3/R4: 20 bytes from 0x13B wrap inside the page
    a = 9'h13B; w0 = wr_cnt; c0 = com_cnt;
    i2c_start();
    send_byte(sel_byte(a[8], 1'b0), ack);
    send_byte(a[7:0], ack);
    chk(ack == 1'b1, "R3 word addr ack", ack, 1);
    for (int k = 0; k < 20; k++) begin
      send_byte(8'(8'h40 + k), ack);
      chk(ack == 1'b1, "R3 data ack", ack, 1);
    end
    i2c_stop(); wclk(4);
    chk(wr_cnt - w0 == 20, "R3 write count", wr_cnt - w0, 20);
    for (int k = 0; k < 20; k++) begin
      logic [8:0] ea;
      ea = {a[8:4], 4'(a[3:0] + 4'(k))};
      chk(log_addr[w0 + k] == ea, "R4 page address", log_addr[w0 + k], ea);
      chk(log_data[w0 + k] == 8'(8'h40 + k), "R3 data", log_data[w0 + k], 8'(8'h40 + k));
    end
    chk(com_cnt - c0 == 1, "R5 one commit", com_cnt - c0, 1);

    // R6: busy blocks everything, polling succeeds afterward
    busy = 1'b1; w0 = wr_cnt; c0 = com_cnt;
    i2c_start(); send_byte(sel_byte(1'b0, 1'b0), ack);
    chk(ack == 1'b0, "R6 busy nack", ack, 0);
    send_byte(8'h10, ack); send_byte(8'hAA, ack); i2c_stop(); wclk(4);
    chk(wr_cnt == w0, "R6 no write", wr_cnt, w0);
    chk(com_cnt == c0, "R6 no commit", com_cnt, c0);
    busy = 1'b0;
    i2c_start(); send_byte(sel_byte(1'b0, 1'b0), ack); i2c_stop();
    chk(ack == 1'b1, "R6 poll ack", ack, 1);

    // R7: protected upper half
    wp = 1'b1; w0 = wr_cnt; c0 = com_cnt;
    i2c_start(); send_byte(sel_byte(1'b1, 1'b0), ack);
    send_byte(8'h20, ack); send_byte(8'h55, ack);
    chk(ack == 1'b0, "R7 data nack", ack, 0);
    i2c_stop(); wclk(4);
    chk(wr_cnt == w0, "R7 no write", wr_cnt, w0);
    chk(com_cnt == c0, "R7 no commit", com_cnt, c0);

    // R8: lower half unaffected by wp
    w0 = wr_cnt;
    i2c_start(); send_byte(sel_byte(1'b0, 1'b0), ack);
    send_byte(8'h20, ack); send_byte(8'h66, ack); i2c_stop(); wclk(4);
    chk(ack == 1'b1 && wr_cnt == w0 + 1, "R8 lower half wp", ack, 1);
    // R8: wp low at capture, raised afterward
    wp = 1'b0; w0 = wr_cnt;
    i2c_start(); send_byte(sel_byte(1'b1, 1'b0), ack); send_byte(8'h30, ack);
    wp = 1'b1;
    send_byte(8'h77, ack); i2c_stop(); wclk(4);
    chk(ack == 1'b1 && wr_cnt == w0 + 1, "R8 late wp rise", ack, 1);
    chk(log_addr[w0] == 9'h130, "R8 address", log_addr[w0], 9'h130);
    // R7: wp high at capture, dropped afterward
    w0 = wr_cnt;
    i2c_start(); send_byte(sel_byte(1'b1, 1'b0), ack); send_byte(8'h31, ack);
    wp = 1'b0;
    send_byte(8'h78, ack); i2c_stop(); wclk(4);
    chk(ack == 1'b0 && wr_cnt == w0, "R7 late wp fall", ack, 0);

    // R9: STOP inside a byte aborts the commit
    w0 = wr_cnt; c0 = com_cnt;
    i2c_start(); send_byte(sel_byte(1'b0, 1'b0), ack); send_byte(8'h50, ack);
    send_byte(8'h01, ack); send_byte(8'h02, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    i2c_stop(); wclk(4);
    chk(wr_cnt == w0 + 2, "R9 bytes strobed", wr_cnt, w0 + 2);
    chk(com_cnt == c0, "R9 stop abort", com_cnt, c0);
    // R9: START inside a byte restarts select decoding
    i2c_start(); send_byte(sel_byte(1'b0, 1'b0), ack); send_byte(8'h60, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    i2c_start();
    send_byte(sel_byte(1'b0, 1'b0), ack);
    chk(ack == 1'b1, "R9 restart ack", ack, 1);
    send_byte(8'h61, ack); send_byte(8'h99, ack); i2c_stop(); wclk(4);
    chk(com_cnt == c0 + 1, "R9 commit after restart", com_cnt, c0 + 1);
    chk(log_addr[wr_cnt - 1] == 9'h061, "R9 restart address", log_addr[wr_cnt - 1], 9'h061);

    // R10
    chk(oe_viol == 0, "R10 oe while scl high", oe_viol, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule